// File: doc/BRIEF.md
# Serial Port Clock Generation Unit

This block turns the system clock into the timing enables that a serial transmitter and receiver need. A reloadable down-counter divides the system clock by a programmable divisor plus one. Each time the counter reaches zero it emits one base tick. The receive enable is that base tick itself. The transmit enable is the base tick divided further, by a ratio that depends on the operating mode.

For synchronous operation the block also chooses where the serial clock comes from. As master it drives a square wave onto the serial clock pin. As slave it samples the pin through a synchroniser and derives both enables from the pin's edges. A polarity control picks which edge feeds the receiver.

Every output is a one-cycle enable pulse in the system clock domain. None is a derived clock. The shift registers, framing and data recovery that consume these enables sit outside this block.

Top module: `serclk_gen`

## Requirements
- R1: With divisor D and no divisor write, `rx_tick` pulses once every D+1 cycles. After reset is released, its first pulse is seen after the 2nd rising edge.
- R2: A pulse on `div_lo_wr` loads the counter with {`div_hi`,`div_lo`} at that edge, so no tick is emitted there. If the write edge is edge W and the new divisor is D2, the next `rx_tick` is seen after edge W+D2+2.
- R3: In asynchronous mode (`sync_mode`=0) with `dbl_speed`=0, `tx_tick` pulses once per 16 base ticks.
- R4: In asynchronous mode with `dbl_speed`=1, `tx_tick` pulses once per 8 base ticks.
- R5: In synchronous master mode (`sync_mode`=1, `pin_is_out`=1), `tx_tick` pulses once per 2 base ticks, and `dbl_speed` has no effect.
- R6: In the internal modes with transmit ratio N, the first `tx_tick` after reset is seen after edge 3+(N-1)(D+1).
- R7: In synchronous master mode, `sclk_out` is a square wave of period 2(D+1) cycles, which is one transmit bit period. In every other mode, `sclk_out` stays 0.
- R8: In asynchronous mode, `sclk_in` has no effect on any output.
- R9: In slave mode (`sync_mode`=1, `pin_is_out`=0), a transition of `sclk_in` first seen at edge E produces a pulse after edge E+2. With `rx_pol`=0, rising edges drive `rx_tick` and falling edges drive `tx_tick`. With `rx_pol`=1, the two are swapped.
- R10: In slave mode, the internal generator drives no enable: with `sclk_in` held steady, `rx_tick` and `tx_tick` stay 0.
- R11: While `rst` is high, all outputs are 0 from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_hi | input | 4 | Upper divisor bits |
| div_lo | input | 8 | Lower divisor bits |
| div_lo_wr | input | 1 | Lower-byte write strobe; reloads the counter |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| dbl_speed | input | 1 | Double speed in asynchronous mode |
| pin_is_out | input | 1 | Serial clock pin direction: 1 = master, 0 = slave |
| rx_pol | input | 1 | Selects the pin edge used for receive in slave mode |
| sclk_in | input | 1 | Serial clock pin input |
| rx_tick | output | 1 | Receive base enable pulse |
| tx_tick | output | 1 | Transmit enable pulse |
| sclk_out | output | 1 | Serial clock pin output (master) |

## Verification
On the internal path, a base tick becomes `rx_tick` two edges after the counter reads zero. `tx_tick` comes one edge after that, on the Nth base tick. A pin transition reaches the outputs on the third edge that sees it.

The bench counts rising edges from the release of reset, or from a stimulus edge, and predicts the exact edge index of every pulse from these latencies. It samples on the falling edge and compares both first-pulse edges and the spacing between pulses. The counts it compares are read one falling edge after each window closes, at a point where no pulse is due.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  typedef enum logic [1:0] {
    SRC_ASYNC  = 2'd0,
    SRC_MASTER = 2'd1,
    SRC_SLAVE  = 2'd2
  } clk_src_e;

  localparam int unsigned TX_CW = 4;

  function automatic clk_src_e pick_src(input logic sync_m, input logic pin_out);
    if (!sync_m) return SRC_ASYNC;
    return pin_out ? SRC_MASTER : SRC_SLAVE;
  endfunction

  // transmit ratio minus one: 16, 8 or 2
  function automatic logic [TX_CW-1:0] tx_ratio_m1(input clk_src_e src, input logic dbl);
    if (src != SRC_ASYNC) return TX_CW'(1);
    return dbl ? TX_CW'(7) : TX_CW'(15);
  endfunction

endpackage

// File: rtl/serclk_baud.sv
module serclk_baud #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             reload,
  output logic             base_tick
);

  logic [DIV_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      base_tick <= 1'b0;
    end else begin
      base_tick <= at_zero && !reload;
      if (reload || at_zero) cnt <= div_val;
      else                   cnt <= cnt - 1'b1;
    end
  end

  p_reload_loads_r2: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == $past(div_val)));

  p_tick_from_zero_r1: assert property (@(posedge clk) disable iff (rst)
    base_tick |-> ($past(cnt) == '0));

endmodule

// File: rtl/serclk_txdiv.sv
module serclk_txdiv
  import serclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             base_tick,
  input  logic [TX_CW-1:0] ratio_m1,
  output logic             tx_pulse,
  output logic             half_tog
);

  logic [TX_CW-1:0] dcnt;
  logic             wrap;
  logic             half;

  assign wrap = (dcnt >= ratio_m1);
  assign half = (dcnt == ratio_m1) || (dcnt == (ratio_m1 >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt     <= '0;
      tx_pulse <= 1'b0;
      half_tog <= 1'b0;
    end else begin
      tx_pulse <= 1'b0;
      if (base_tick) begin
        if (wrap) begin
          dcnt     <= '0;
          tx_pulse <= 1'b1;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
        if (half) half_tog <= ~half_tog;
      end
    end
  end

  p_tx_needs_base_r3: assert property (@(posedge clk) disable iff (rst)
    tx_pulse |-> $past(base_tick));

  p_tog_needs_base_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(base_tick) |-> $stable(half_tog));

endmodule

// File: rtl/serclk_extsync.sv
module serclk_extsync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= synced;
  end

  assign rise = synced && !prev_q;
  assign fall = !synced && prev_q;

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
  import serclk_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned LO_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-LO_W-1:0] div_hi,
  input  logic [LO_W-1:0]   div_lo,
  input  logic              div_lo_wr,
  input  logic              sync_mode,
  input  logic              dbl_speed,
  input  logic              pin_is_out,
  input  logic              rx_pol,
  input  logic              sclk_in,
  output logic              rx_tick,
  output logic              tx_tick,
  output logic              sclk_out
);

  clk_src_e         src;
  logic [TX_CW-1:0] ratio_m1;
  logic             base_tick;
  logic             tx_int;
  logic             half_tog;
  logic             ext_rise;
  logic             ext_fall;
  logic             ext_rx;
  logic             ext_tx;

  assign src      = pick_src(sync_mode, pin_is_out);
  assign ratio_m1 = tx_ratio_m1(src, dbl_speed);

  serclk_baud #(.DIV_W(DIV_W)) u_baud (
    .clk       (clk),
    .rst       (rst),
    .div_val   ({div_hi, div_lo}),
    .reload    (div_lo_wr),
    .base_tick (base_tick)
  );

  serclk_txdiv u_txdiv (
    .clk       (clk),
    .rst       (rst),
    .base_tick (base_tick),
    .ratio_m1  (ratio_m1),
    .tx_pulse  (tx_int),
    .half_tog  (half_tog)
  );

  serclk_extsync #(.SYNC_STAGES(2)) u_ext (
    .clk    (clk),
    .rst    (rst),
    .pin_in (sclk_in),
    .rise   (ext_rise),
    .fall   (ext_fall)
  );

  assign ext_rx = rx_pol ? ext_fall : ext_rise;
  assign ext_tx = rx_pol ? ext_rise : ext_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_tick  <= 1'b0;
      tx_tick  <= 1'b0;
      sclk_out <= 1'b0;
    end else begin
      case (src)
        SRC_SLAVE: begin
          rx_tick  <= ext_rx;
          tx_tick  <= ext_tx;
          sclk_out <= 1'b0;
        end
        SRC_MASTER: begin
          rx_tick  <= base_tick;
          tx_tick  <= tx_int;
          sclk_out <= half_tog;
        end
        default: begin
          rx_tick  <= base_tick;
          tx_tick  <= tx_int;
          sclk_out <= 1'b0;
        end
      endcase
    end
  end

  p_pin_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !(sync_mode && pin_is_out) |=> !sclk_out);

  p_slave_excl_r9: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && !pin_is_out) |=> !(rx_tick && tx_tick));

  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && !pin_is_out && !ext_rise && !ext_fall) |=> (!rx_tick && !tx_tick));

  p_reset_clears_r11: assert property (@(posedge clk)
    $past(rst) |-> (!rx_tick && !tx_tick && !sclk_out));

endmodule

// File: tb/serclk_gen_bench.sv
module serclk_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] div_hi = '0;
  logic [7:0] div_lo = '0;
  logic       div_lo_wr = 1'b0;
  logic       sync_mode = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       pin_is_out = 1'b0;
  logic       rx_pol = 1'b0;
  logic       sclk_in = 1'b0;
  logic       rx_tick, tx_tick, sclk_out;

  int n_chk = 0;
  int n_bad = 0;
  int ecount = 0;
  int rx_cnt, rx_first, rx_prev, rx_last;
  int tx_cnt, tx_first, tx_prev, tx_last;
  int pr_cnt, pr_prev, pr_last;
  logic pin_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  serclk_gen u_serclk_gen (
    .clk(clk), .rst(rst), .div_hi(div_hi), .div_lo(div_lo), .div_lo_wr(div_lo_wr),
    .sync_mode(sync_mode), .dbl_speed(dbl_speed), .pin_is_out(pin_is_out),
    .rx_pol(rx_pol), .sclk_in(sclk_in),
    .rx_tick(rx_tick), .tx_tick(tx_tick), .sclk_out(sclk_out)
  );

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      rx_cnt = 0; rx_first = -1; rx_prev = -1; rx_last = -1;
      tx_cnt = 0; tx_first = -1; tx_prev = -1; tx_last = -1;
      pr_cnt = 0; pr_prev = -1; pr_last = -1;
      pin_d = 1'b0;
    end else begin
      if (rx_tick) begin
        if (rx_cnt == 0) rx_first = ecount;
        rx_prev = rx_last; rx_last = ecount; rx_cnt++;
      end
      if (tx_tick) begin
        if (tx_cnt == 0) tx_first = ecount;
        tx_prev = tx_last; tx_last = ecount; tx_cnt++;
      end
      if (sclk_out && !pin_d) begin
        pr_prev = pr_last; pr_last = ecount; pr_cnt++;
      end
      pin_d = sclk_out;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_edge(input int n);
    while (ecount < n) @(negedge clk);
    @(negedge clk);
  endtask

  // {sync, dbl, master, divisor[11:0]}
  localparam logic [14:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 12'd3},
    {1'b0, 1'b1, 1'b0, 12'd3},
    {1'b1, 1'b0, 1'b1, 12'd4},
    {1'b1, 1'b1, 1'b1, 12'd2},
    {1'b0, 1'b0, 1'b0, 12'd0},
    {1'b0, 1'b1, 1'b0, 12'd10}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int d, r, c;
    // R11: outputs held low during reset, even with a fast divisor
    div_hi = 4'd0; div_lo = 8'd0;
    @(negedge clk);
    chk("R11 rx_tick in reset", int'(rx_tick), 0);
    chk("R11 tx_tick in reset", int'(tx_tick), 0);
    chk("R11 sclk_out in reset", int'(sclk_out), 0);

    for (int i = 0; i < 6; i++) begin
      sync_mode  = VEC[i][14];
      dbl_speed  = VEC[i][13];
      pin_is_out = VEC[i][12];
      {div_hi, div_lo} = VEC[i][11:0];
      d = int'(VEC[i][11:0]);
      r = sync_mode ? 2 : (dbl_speed ? 8 : 16);
      do_reset();
      wait_edge(3 + 3 * r * (d + 1));
      chk($sformatf("R1 vec%0d rx first", i), rx_first, 2);
      chk($sformatf("R1 vec%0d rx spacing", i), rx_last - rx_prev, d + 1);
      chk($sformatf("R6 vec%0d tx first", i), tx_first, 3 + (r - 1) * (d + 1));
      if (r == 16)     chk($sformatf("R3 vec%0d tx spacing", i), tx_last - tx_prev, 16 * (d + 1));
      else if (r == 8) chk($sformatf("R4 vec%0d tx spacing", i), tx_last - tx_prev, 8 * (d + 1));
      else             chk($sformatf("R5 vec%0d tx spacing", i), tx_last - tx_prev, 2 * (d + 1));
      if (sync_mode && pin_is_out)
        chk($sformatf("R7 vec%0d pin period", i), pr_last - pr_prev, 2 * (d + 1));
      else
        chk($sformatf("R7 vec%0d pin idle", i), pr_cnt, 0);
    end

    // R11: reset mid-run clears outputs on the first edge
    sync_mode = 1'b1; pin_is_out = 1'b1; dbl_speed = 1'b0; {div_hi, div_lo} = 12'd0;
    do_reset();
    wait_edge(7);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 rx after reset edge", int'(rx_tick), 0);
    chk("R11 tx after reset edge", int'(tx_tick), 0);
    chk("R11 pin after reset edge", int'(sclk_out), 0);

    // R2: lower-byte write reloads the counter
    sync_mode = 1'b0; pin_is_out = 1'b0; {div_hi, div_lo} = 12'd100;
    do_reset();
    while (ecount < 9) @(negedge clk);
    {div_hi, div_lo} = 12'd5;
    div_lo_wr = 1'b1;
    @(negedge clk);
    div_lo_wr = 1'b0;
    wait_edge(20);
    chk("R2 rx count after reload", rx_cnt, 2);
    chk("R2 rx edge after reload", rx_last, 17);

    // R8: pin activity ignored in asynchronous mode
    {div_hi, div_lo} = 12'd3;
    do_reset();
    while (ecount < 40) begin
      sclk_in = ~sclk_in;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R8 rx count with pin toggling", rx_cnt, 10);
    chk("R8 rx spacing with pin toggling", rx_last - rx_prev, 4);
    chk("R8 pin out idle", pr_cnt, 0);
    sclk_in = 1'b0;

    // R10 / R9: slave mode, polarity 0
    sync_mode = 1'b1; pin_is_out = 1'b0; rx_pol = 1'b0; {div_hi, div_lo} = 12'd0;
    do_reset();
    wait_edge(20);
    chk("R10 slave rx quiet", rx_cnt, 0);
    chk("R10 slave tx quiet", tx_cnt, 0);
    c = ecount; sclk_in = 1'b1;
    wait_edge(c + 6);
    chk("R9 pol0 rise to rx edge", rx_last, c + 3);
    chk("R9 pol0 rise no tx", tx_cnt, 0);
    c = ecount; sclk_in = 1'b0;
    wait_edge(c + 6);
    chk("R9 pol0 fall to tx edge", tx_last, c + 3);
    chk("R9 pol0 rx count", rx_cnt, 1);

    // R9: polarity 1 swaps edges
    rx_pol = 1'b1;
    do_reset();
    wait_edge(5);
    c = ecount; sclk_in = 1'b1;
    wait_edge(c + 6);
    chk("R9 pol1 rise to tx edge", tx_last, c + 3);
    chk("R9 pol1 rise no rx", rx_cnt, 0);
    c = ecount; sclk_in = 1'b0;
    wait_edge(c + 6);
    chk("R9 pol1 fall to rx edge", rx_last, c + 3);
    chk("R7 slave pin idle", pr_cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule